// File: doc/BRIEF.md
# Watchdog Timer With Coded Interval

This block is a watchdog for a system that must be reset when its software stops responding. Software drives a single write-only control byte. One bit switches the watchdog on or off, one bit is a "kick" that restarts the timeout, and a three-bit code picks the timeout length in quarter-second units. Codes one to seven select that many units. Code zero selects eight units, the longest interval.

The time base comes from a one-cycle `tick` input that acts as a clock enable. A parameter sets how many ticks make one unit. The block counts ticks into units and units up to the selected limit. If the limit is reached before a kick arrives, it raises `wdt_rst_o` for exactly one clock and starts timing again from zero.

A new code written without a kick does not cut short the interval that is running. It applies from the next kick, the next overflow or the next enable.

Top module: `wdt_coded_top`

## Requirements
- R1: Bit 7 of a control write is the enable. While it is 0, no ticks are counted and `wdt_rst_o` stays low. A write with bit 7 = 0 also discards any partial count.
- R2: Bit 6 of a control write is a kick that restarts the timeout from zero. It is a strobe and is not stored, so a later write without bit 6 does not restart the count.
- R3: One unit is `TICKS_PER_UNIT` tick pulses, and `TICKS_PER_UNIT` must be at least 2. Interval codes 1 to 7 (bits 2:0 of the write) give that many units.
- R4: Interval code 0 gives 8 units.
- R5: On the clock edge that samples the tick completing the interval, `wdt_rst_o` goes high for exactly one cycle. Counting then restarts from zero with no gap.
- R6: After `rst_n` is released, the watchdog is disabled, the stored code is 0 and `wdt_rst_o` is low.
- R7: A code written without a kick while the watchdog is running does not change the interval in progress. It takes effect from the next kick, overflow or enable.
- R8: A kick written in the same cycle as the completing tick wins. No pulse is produced and a full new interval begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte: [7] enable, [6] kick, [2:0] interval code |
| tick | input | 1 | One-cycle time-base pulse |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with `TICKS_PER_UNIT` = 4. This makes even the longest interval, code 0 at eight units, only 32 tick pulses long. Every interval code, back-to-back overflows, mid-interval kicks and a kick that collides with the final tick can therefore be checked to the exact tick. The same value keeps the tick divider's wrap point and the unit counter's limit compare both in play within each run.

// File: rtl/wdt_coded_pkg.sv
package wdt_coded_pkg;
    localparam int DATA_W    = 8;
    localparam int EN_BIT    = 7;
    localparam int KICK_BIT  = 6;
    localparam int CODE_W    = 3;
    localparam int MAX_UNITS = 1 << CODE_W;
    localparam int UNIT_W    = $clog2(MAX_UNITS + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [UNIT_W-1:0] unit_t;

    typedef struct packed {
        logic  en;
        code_t code;
    } ctrl_s;

    typedef struct packed {
        unit_t units;
        unit_t limit;
        logic  pulse;
    } cnt_s;

    // code 0 selects the longest interval, others map directly
    function automatic unit_t code_to_units(code_t c);
        if (c == '0) return unit_t'(MAX_UNITS);
        return unit_t'(c);
    endfunction
endpackage

// File: rtl/wdt_coded_ctrl.sv
module wdt_coded_ctrl
    import wdt_coded_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_enable_bit,
    input  logic  wr_kick_bit,
    input  code_t wr_code,
    output logic  en_o,
    output code_t code_next_o,
    output logic  restart_o
);
    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.en   = wr_enable_bit;
            ctl_d.code = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_o        = ctl_q.en;
    assign code_next_o = ctl_d.code;
    // kick, disable, or enable from off all restart timing
    assign restart_o   = wr_en & (wr_kick_bit | ~wr_enable_bit | ~ctl_q.en);

    assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(en_o) && $stable(ctl_q.code)));
endmodule

// File: rtl/wdt_coded_prescale.sv
module wdt_coded_prescale #(
    parameter int TICKS_PER_UNIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic restart,
    input  logic tick,
    output logic unit_done_o
);
    localparam int PRE_W = $clog2(TICKS_PER_UNIT);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (hold || restart)       pre_d = '0;
        else if (tick) begin
            if (pre_q == PRE_LAST) pre_d = '0;
            else                   pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign unit_done_o = ~hold & ~restart & tick & (pre_q == PRE_LAST);

    assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
    assert_pre_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pre_q == '0));
endmodule

// File: rtl/wdt_coded_units.sv
module wdt_coded_units
    import wdt_coded_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  restart,
    input  logic  unit_done,
    input  code_t code_next,
    output logic  pulse_o
);
    cnt_s cnt_d, cnt_q;
    unit_t units_inc;

    assign units_inc = cnt_q.units + 1'b1;

    always_comb begin
        cnt_d       = cnt_q;
        cnt_d.pulse = 1'b0;
        if (hold || restart) begin
            cnt_d.units = '0;
            cnt_d.limit = code_to_units(code_next);
        end else if (unit_done) begin
            if (units_inc == cnt_q.limit) begin
                cnt_d.units = '0;
                cnt_d.pulse = 1'b1;
                cnt_d.limit = code_to_units(code_next);
            end else begin
                cnt_d.units = units_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q.units <= '0;
            cnt_q.limit <= code_to_units('0);
            cnt_q.pulse <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse_o = cnt_q.pulse;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    assert_unit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.units < cnt_q.limit) && (cnt_q.limit != '0));
    assert_limit_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold || restart || unit_done) |=> $stable(cnt_q.limit));
    assert_kick_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q.units == '0 && !pulse_o));
endmodule

// File: rtl/wdt_coded_top.sv
module wdt_coded_top
    import wdt_coded_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              wdt_rst_o
);
    logic  en;
    logic  restart;
    logic  unit_done;
    code_t code_next;
    logic  unused_bits;

    assign unused_bits = ^wr_data[KICK_BIT-1:CODE_W];

    wdt_coded_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_enable_bit (wr_data[EN_BIT]),
        .wr_kick_bit   (wr_data[KICK_BIT]),
        .wr_code       (wr_data[CODE_W-1:0]),
        .en_o          (en),
        .code_next_o   (code_next),
        .restart_o     (restart)
    );

    wdt_coded_prescale #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (~en),
        .restart     (restart),
        .tick        (tick),
        .unit_done_o (unit_done)
    );

    wdt_coded_units u_units (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (~en),
        .restart   (restart),
        .unit_done (unit_done),
        .code_next (code_next),
        .pulse_o   (wdt_rst_o)
    );

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> $past(en));
endmodule

// File: tb/wdt_coded_top_bench.sv
module wdt_coded_top_bench;
    localparam int TPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic       wdt_rst_o;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_coded_top #(.TICKS_PER_UNIT(TPU)) u_wdt_coded_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .wdt_rst_o(wdt_rst_o)
    );

    always @(negedge clk) if (rst_n && wdt_rst_o) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // exactly n ticks to the pulse, pulse one cycle wide
    task automatic expect_interval(input int n, input string req);
        int p0;
        p0 = pulses;
        give_ticks(n - 1);
        #1;
        check(pulses == p0 && !wdt_rst_o, req, pulses - p0, 0);
        give_ticks(1);
        check(wdt_rst_o == 1'b1, req, int'(wdt_rst_o), 1);
        @(negedge clk);
        check(wdt_rst_o == 1'b0, {req, " R5 width"}, int'(wdt_rst_o), 0);
    endtask

    task automatic t_reset_state;
        int p0;
        check(wdt_rst_o == 1'b0, "R6 output", int'(wdt_rst_o), 0);
        p0 = pulses;
        give_ticks(40);
        #1;
        check(pulses == p0, "R6 disabled after reset", pulses - p0, 0);
        // enable without kick, code bits 0 -> 8 units
        write_ctl(8'h80);
        expect_interval(8 * TPU, "R6 code 0 after reset");
    endtask

    task automatic t_codes;
        write_ctl(8'hC3);
        expect_interval(3 * TPU, "R3 code 3");
        expect_interval(3 * TPU, "R5 restart after overflow");
        write_ctl(8'hC1);
        expect_interval(1 * TPU, "R3 code 1");
        write_ctl(8'hC7);
        expect_interval(7 * TPU, "R3 code 7");
        write_ctl(8'hC0);
        expect_interval(8 * TPU, "R4 code 0");
    endtask

    task automatic t_kick;
        write_ctl(8'hC2);
        give_ticks(6);
        write_ctl(8'hC2);
        expect_interval(2 * TPU, "R2 kick restarts");
        give_ticks(5);
        write_ctl(8'h82);
        expect_interval(2 * TPU - 5, "R2 kick not stored");
    endtask

    task automatic t_disable;
        int p0;
        write_ctl(8'hC1);
        give_ticks(2);
        write_ctl(8'h01);
        p0 = pulses;
        give_ticks(30);
        #1;
        check(pulses == p0, "R1 disabled no pulse", pulses - p0, 0);
        write_ctl(8'h81);
        expect_interval(TPU, "R1 partial count discarded");
    endtask

    task automatic t_code_change;
        write_ctl(8'hC2);
        give_ticks(3);
        write_ctl(8'h85);
        expect_interval(2 * TPU - 3, "R7 old interval kept");
        expect_interval(5 * TPU, "R7 new code after overflow");
    endtask

    task automatic t_collision;
        int p0;
        write_ctl(8'hC1);
        give_ticks(TPU - 1);
        p0 = pulses;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hC1; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        check(wdt_rst_o == 1'b0, "R8 kick wins", int'(wdt_rst_o), 0);
        @(negedge clk); #1;
        check(pulses == p0, "R8 no pulse", pulses - p0, 0);
        expect_interval(TPU, "R8 full interval after");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_codes();
        t_kick();
        t_disable();
        t_code_change();
        t_collision();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end
endmodule